// File: doc/BRIEF.md
# Staggered CAS-before-RAS Refresh Sequencer

This block keeps a DRAM array alive without any help from software. The array is built from four double-sided modules, which gives eight row-strobe groups. From the moment reset is released, a divider on the system clock marks out evenly spaced refresh events. There is one event every 15.6 µs, so that each of 2048 rows is visited within a 32 ms retention window. Each event walks the eight groups one after another instead of strobing them together, which keeps the supply current spread out. Each group gets a single CAS-before-RAS cycle, with the column strobe of every byte lane falling before the group's row strobe.

Because the DRAM counts rows internally during a CAS-before-RAS cycle, the sequencer never drives a row address. It lowers the address-bus output enable for the whole burst so the bus floats. The sequencer shares the array with a host access port. A refresh that falls due while a host cycle is running waits until that cycle ends. Once a burst has been committed, a busy flag holds the host off until the last group has recovered. Refresh events that pile up behind a long host cycle are counted rather than lost, and a sticky flag records that this happened.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, every row strobe and column strobe is high (inactive), the address output enable is high, busy is low and the overrun flag is low.
- R2: Successive refresh bursts start exactly CLK_PER_EVENT clocks apart when no host cycle interferes.
- R3: Within a burst the groups are strobed in order 0, 1, ... GROUPS-1, and no two row strobes are ever low at the same time; ras_n bit g belongs to group g.
- R4: For each group, all cas_n lanes go low T_CSR clocks before that group's ras_n falls. Both then stay low together for T_RAS clocks, and both stay high for T_RP clocks before the next group's cas_n falls.
- R5: addr_oe is low for the whole burst, from the first column strobe through the last recovery period, and high otherwise.
- R6: ref_busy is high from the clock in which a burst is committed until the final recovery period ends.
- R7: No strobe moves while host_cycle is high. A refresh that fell due during the host cycle raises ref_busy in the same clock that host_cycle falls, and its first column strobe appears one clock later.
- R8: A refresh event that falls due while a burst is running or another event is still waiting sets overrun, which then stays high until reset. The waiting event is kept and starts one idle clock after the running burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cycle | input | 1 | High while the host owns the array for an access |
| ref_busy | output | 1 | Host must not start a cycle while high |
| addr_oe | output | 1 | Address-bus output enable, low while refreshing |
| ras_n | output | GROUPS | Active-low row strobe, one per group |
| cas_n | output | LANES | Active-low column strobe, one per byte lane |
| overrun | output | 1 | Sticky: a refresh event fell due while another was unfinished |

## Verification
The properties assume the host follows the handshake: host_cycle rises only in a clock where ref_busy is low. The check that strobes stay still during a host cycle depends on this. The bench raises host_cycle only right after reset, or at a falling edge where it has just seen ref_busy low. It lowers host_cycle freely, since a falling host request can never collide with a burst.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int GROUPS        = 8,
  parameter int LANES         = 4,
  parameter int CLK_PER_EVENT = 312,
  parameter int T_CSR         = 1,
  parameter int T_RAS         = 4,
  parameter int T_RP          = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cycle,
  output logic              ref_busy,
  output logic              addr_oe,
  output logic [GROUPS-1:0] ras_n,
  output logic [LANES-1:0]  cas_n,
  output logic              overrun
);
  localparam int TW   = (CLK_PER_EVENT > 1) ? $clog2(CLK_PER_EVENT) : 1;
  localparam int GW   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int TMX0 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int TMAX = (TMX0 > T_RP) ? TMX0 : T_RP;
  localparam int DW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_CSR, PH_RAS, PH_RP} phase_t;

  phase_t        ph;
  logic [TW-1:0] tmr;
  logic [1:0]    pend;
  logic [DW-1:0] dcnt;
  logic [GW-1:0] grp;
  logic          tick, start, last;

  assign tick  = tmr == TW'(CLK_PER_EVENT - 1);
  assign start = (ph == PH_IDLE) && (pend != 2'd0) && !host_cycle;
  assign last  = dcnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr     <= '0;
      pend    <= 2'd0;
      overrun <= 1'b0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      case ({tick, start})
        2'b10:   if (pend != 2'd3) pend <= pend + 2'd1;
        2'b01:   pend <= pend - 2'd1;
        default: pend <= pend;
      endcase
      if (tick && (pend != 2'd0 || ph != PH_IDLE)) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      dcnt <= '0;
      grp  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph   <= PH_CSR;
          dcnt <= DW'(T_CSR - 1);
          grp  <= '0;
        end
        PH_CSR: if (last) begin
          ph   <= PH_RAS;
          dcnt <= DW'(T_RAS - 1);
        end else dcnt <= dcnt - 1'b1;
        PH_RAS: if (last) begin
          ph   <= PH_RP;
          dcnt <= DW'(T_RP - 1);
        end else dcnt <= dcnt - 1'b1;
        PH_RP: if (last) begin
          if (grp == GW'(GROUPS - 1)) ph <= PH_IDLE;
          else begin
            ph   <= PH_CSR;
            grp  <= grp + 1'b1;
            dcnt <= DW'(T_CSR - 1);
          end
        end else dcnt <= dcnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign ref_busy = (ph != PH_IDLE) || ((pend != 2'd0) && !host_cycle);
  assign addr_oe  = ph == PH_IDLE;
  assign cas_n    = (ph == PH_CSR || ph == PH_RAS) ? '0 : '1;
  assign ras_n    = (ph == PH_RAS) ? ~(GROUPS'(1) << grp) : '1;
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int GROUPS = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cycle,
  input logic              ref_busy,
  input logic              addr_oe,
  input logic [GROUPS-1:0] ras_n,
  input logic [LANES-1:0]  cas_n,
  input logic              overrun
);
  // R3
  one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ras_n) <= 1);

  // R4
  cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != '1 && $past(ras_n) == '1) |-> $past(cas_n) == '0);

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != '1) |-> cas_n == '0);

  // R5
  addr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n != '1 || cas_n != '1) |-> !addr_oe);

  // R6
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> ref_busy);

  // R7
  host_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_cycle |-> (ras_n == '1 && cas_n == '1));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> overrun);
endmodule

bind dram_refresh_sched ref_sched_chk #(.GROUPS(GROUPS), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cycle(host_cycle), .ref_busy(ref_busy),
  .addr_oe(addr_oe), .ras_n(ras_n), .cas_n(cas_n), .overrun(overrun)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cycle = 1'b0;
  logic       ref_busy, addr_oe, overrun;
  logic [7:0] ras_n;
  logic [3:0] cas_n;
  int checks = 0, errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sched #(.GROUPS(8), .LANES(4), .CLK_PER_EVENT(100),
                       .T_CSR(1), .T_RAS(3), .T_RP(2)) u0 (
    .clk(clk), .rst_n(rst_n), .host_cycle(host_cycle), .ref_busy(ref_busy),
    .addr_oe(addr_oe), .ras_n(ras_n), .cas_n(cas_n), .overrun(overrun));

  // {offset, ras_n, cas_low, busy, addr_oe}; offset 0 = first clock with cas low
  localparam int NV = 15;
  localparam logic [18:0] VEC [NV] = '{
    {8'd0,  8'hFF, 3'b110}, {8'd1,  8'hFE, 3'b110}, {8'd3,  8'hFE, 3'b110},
    {8'd4,  8'hFF, 3'b010}, {8'd5,  8'hFF, 3'b010}, {8'd6,  8'hFF, 3'b110},
    {8'd7,  8'hFD, 3'b110}, {8'd13, 8'hFB, 3'b110}, {8'd19, 8'hF7, 3'b110},
    {8'd25, 8'hEF, 3'b110}, {8'd31, 8'hDF, 3'b110}, {8'd37, 8'hBF, 3'b110},
    {8'd43, 8'h7F, 3'b110}, {8'd47, 8'hFF, 3'b010}, {8'd48, 8'hFF, 3'b001}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cas;
    for (int i = 0; i < 400 && cas_n != 4'h0; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t1, t2, bad;
    do_reset;
    #1;
    // R1 reset state
    chk(ras_n == 8'hFF && cas_n == 4'hF, "R1 strobes", {ras_n, cas_n}, 12'hFFF);
    chk(addr_oe && !ref_busy && !overrun, "R1 flags",
        {addr_oe, ref_busy, overrun}, 3'b100);

    // R3 R4 R5 R6 burst shape
    @(negedge clk);
    wait_cas;
    t1 = cyc;
    begin
      int cur = 0;
      for (int i = 0; i < NV; i++) begin
        repeat (int'(VEC[i][18:11]) - cur) @(negedge clk);
        cur = int'(VEC[i][18:11]);
        chk(ras_n == VEC[i][10:3], "R3 R4 ras_n", ras_n, VEC[i][10:3]);
        chk((cas_n == 4'h0) == VEC[i][2], "R4 cas_n", cas_n, VEC[i][2] ? 0 : 15);
        chk(ref_busy == VEC[i][1], "R6 busy", ref_busy, VEC[i][1]);
        chk(addr_oe == VEC[i][0], "R5 addr_oe", addr_oe, VEC[i][0]);
      end
    end

    // R2 interval
    wait_cas;
    t2 = cyc;
    chk(t2 - t1 == 100, "R2 interval", t2 - t1, 100);

    // R7 deferral behind a host cycle
    for (int i = 0; i < 100 && ref_busy; i++) @(negedge clk);
    host_cycle = 1'b1;
    bad = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (ras_n != 8'hFF || cas_n != 4'hF || ref_busy) bad++;
    end
    chk(bad == 0, "R7 quiet during host", bad, 0);
    host_cycle = 1'b0;
    #1;
    chk(ref_busy, "R7 busy on release", ref_busy, 1);
    @(negedge clk);
    chk(cas_n == 4'h0, "R7 start after release", cas_n, 0);
    chk(!overrun, "R8 no overrun", overrun, 0);

    // R8 overrun and queued event
    do_reset;
    host_cycle = 1'b1;
    repeat (250) @(negedge clk);
    chk(overrun, "R8 overrun set", overrun, 1);
    host_cycle = 1'b0;
    @(negedge clk);
    chk(cas_n == 4'h0, "R8 first burst", cas_n, 0);
    repeat (48) @(negedge clk);
    chk(ref_busy && ras_n == 8'hFF && cas_n == 4'hF, "R8 gap",
        {ref_busy, cas_n}, 5'h1F);
    @(negedge clk);
    chk(cas_n == 4'h0, "R8 queued burst", cas_n, 0);
    chk(overrun, "R8 sticky", overrun, 1);

    do_reset;
    #1;
    chk(!overrun && addr_oe, "R1 reset clears", {overrun, addr_oe}, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule